// File: doc/BRIEF.md
# Configurable Embedded Multiplier

This block is a hard-multiplier style arithmetic unit. It takes two 18-bit operands and returns their full 36-bit product, or, when switched into split mode, works as two independent 9x9 multipliers that each return an 18-bit result in one half of the product bus. Each operand has its own sign control, so any mix of signed and unsigned interpretation can be chosen per operation.

Two register stages can be put in the path, one on the operand side and one on the product side, each switched in by its own configuration bit. The latency is therefore zero, one or two clock cycles. A valid flag travels alongside the data through exactly the same stages. Every enabled register shares one clock, one clock enable and one synchronous clear.

Top module: `cfg_mult`

## Requirements
- R1: With split_mode low and both sign controls low, product equals the full 36-bit unsigned product of x and y.
- R2: A high x_signed or y_signed marks that operand as two's complement. Only a signed operand is sign-extended before the multiply, and product holds the low 36 bits of the true result.
- R3: With split_mode high, product[17:0] is x[8:0] times y[8:0] and product[35:18] is x[17:9] times y[17:9]. The sign controls apply to bit 8 and bit 17, which are the top bits of the 9-bit operands.
- R4: With in_reg_en high, the operands, sign controls, mode and in_valid are registered, which adds one cycle of latency.
- R5: With out_reg_en high, the product is registered, which adds one cycle of latency. With both enables high the latency is two cycles. With both low, product follows the inputs within the same cycle.
- R6: out_valid reproduces in_valid with the same latency as product, so a one-cycle in_valid pulse gives exactly one cycle of out_valid.
- R7: While ce is low, every enabled register keeps its value, so product and out_valid stay fixed even when the inputs change.
- R8: clr zeros every pipeline register and valid bit at the next clock edge, and it does so even while ce is low.
- R9: In split mode each lane's result depends only on that lane's operand bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all register stages |
| ce | input | 1 | Clock enable for all register stages |
| clr | input | 1 | Synchronous clear of all registers and valid bits |
| split_mode | input | 1 | 1 selects two 9x9 lanes, 0 selects one 18x18 multiply |
| in_reg_en | input | 1 | Enables the operand register stage |
| out_reg_en | input | 1 | Enables the product register stage |
| in_valid | input | 1 | Marks the current operands as valid |
| x | input | 18 | First operand |
| y | input | 18 | Second operand |
| x_signed | input | 1 | 1 treats x (or each x lane) as two's complement |
| y_signed | input | 1 | 1 treats y (or each y lane) as two's complement |
| product | output | 36 | Product, or two 18-bit lane products in split mode |
| out_valid | output | 1 | Valid flag aligned with product |

## Verification
A faulty sign extension or a wrong lane boundary shows on the product bus on the very cycle the configured latency expires, usually in the upper bits or across the lane seam at bit 18. A stage register that ignores clock enable or clear shows up as a changed product or a stray out_valid one edge after the stimulus. A valid pipeline that does not match the data path shows as out_valid arriving one cycle early, arriving one cycle late, or being stretched, compared with the cycle in which the correct product appears.

// File: rtl/cfg_mult.sv
module cfg_mult #(
  parameter int OPW = 18
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             clr,
  input  logic             split_mode,
  input  logic             in_reg_en,
  input  logic             out_reg_en,
  input  logic             in_valid,
  input  logic [OPW-1:0]   x,
  input  logic [OPW-1:0]   y,
  input  logic             x_signed,
  input  logic             y_signed,
  output logic [2*OPW-1:0] product,
  output logic             out_valid
);
  localparam int HW  = OPW / 2;
  localparam int HPW = 2 * HW;
  localparam int PW  = 2 * OPW;

  logic [OPW-1:0] s1_x, s1_y;
  logic           s1_sx, s1_sy, s1_split, s1_vld;

  always_ff @(posedge clk) begin
    if (clr) begin
      s1_x <= '0; s1_y <= '0; s1_sx <= 1'b0; s1_sy <= 1'b0;
      s1_split <= 1'b0; s1_vld <= 1'b0;
    end else if (ce) begin
      s1_x <= x; s1_y <= y; s1_sx <= x_signed; s1_sy <= y_signed;
      s1_split <= split_mode; s1_vld <= in_valid;
    end
  end

  logic [OPW-1:0] a_x, a_y;
  logic           a_sx, a_sy, a_split, a_vld;

  assign a_x     = in_reg_en ? s1_x     : x;
  assign a_y     = in_reg_en ? s1_y     : y;
  assign a_sx    = in_reg_en ? s1_sx    : x_signed;
  assign a_sy    = in_reg_en ? s1_sy    : y_signed;
  assign a_split = in_reg_en ? s1_split : split_mode;
  assign a_vld   = in_reg_en ? s1_vld   : in_valid;

  logic [PW-1:0] ext_x, ext_y, full_p;
  assign ext_x  = {{(PW-OPW){a_sx & a_x[OPW-1]}}, a_x};
  assign ext_y  = {{(PW-OPW){a_sy & a_y[OPW-1]}}, a_y};
  assign full_p = ext_x * ext_y;

  logic [HPW-1:0] lane_p [2];
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HW-1:0]  lx, ly;
    logic [HPW-1:0] ex, ey;
    assign lx = a_x[g*HW +: HW];
    assign ly = a_y[g*HW +: HW];
    assign ex = {{(HPW-HW){a_sx & lx[HW-1]}}, lx};
    assign ey = {{(HPW-HW){a_sy & ly[HW-1]}}, ly};
    assign lane_p[g] = ex * ey;
  end

  logic [PW-1:0] comb_p;
  assign comb_p = a_split ? {lane_p[1], lane_p[0]} : full_p;

  logic [PW-1:0] s2_p;
  logic          s2_vld;

  always_ff @(posedge clk) begin
    if (clr) begin
      s2_p <= '0; s2_vld <= 1'b0;
    end else if (ce) begin
      s2_p <= comb_p; s2_vld <= a_vld;
    end
  end

  assign product   = out_reg_en ? s2_p   : comb_p;
  assign out_valid = out_reg_en ? s2_vld : a_vld;
endmodule

// File: rtl/cfg_mult_chk.sv
module cfg_mult_chk #(
  parameter int OPW = 18
) (
  input logic             clk,
  input logic             ce,
  input logic             clr,
  input logic             in_reg_en,
  input logic             out_reg_en,
  input logic             in_valid,
  input logic [2*OPW-1:0] product,
  input logic             out_valid
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  a_r6_valid_comb: assert property (@(posedge clk) disable iff (clr || !armed)
    (!in_reg_en && !out_reg_en) |-> (out_valid == in_valid));

  a_r4_valid_one_stage: assert property (@(posedge clk) disable iff (clr || !armed)
    (in_reg_en && !out_reg_en && $past(in_reg_en) && !$past(out_reg_en)
     && $past(ce) && !$past(clr)) |-> (out_valid == $past(in_valid)));

  a_r7_hold: assert property (@(posedge clk) disable iff (clr || !armed)
    (out_reg_en && $past(out_reg_en) && !$past(ce) && !$past(clr))
    |-> ($stable(product) && $stable(out_valid)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr) && out_reg_en) |-> (!out_valid && product == '0));
endmodule

bind cfg_mult cfg_mult_chk #(.OPW(OPW)) u_chk (
  .clk(clk), .ce(ce), .clr(clr), .in_reg_en(in_reg_en),
  .out_reg_en(out_reg_en), .in_valid(in_valid),
  .product(product), .out_valid(out_valid)
);

// File: tb/cfg_mult_bench.sv
module cfg_mult_bench;
  logic        clk = 1'b0;
  logic        ce, clr, split_mode, in_reg_en, out_reg_en, in_valid;
  logic [17:0] x, y;
  logic        x_signed, y_signed;
  logic [35:0] product;
  logic        out_valid;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  cfg_mult u_cfg_mult (
    .clk(clk), .ce(ce), .clr(clr), .split_mode(split_mode),
    .in_reg_en(in_reg_en), .out_reg_en(out_reg_en), .in_valid(in_valid),
    .x(x), .y(y), .x_signed(x_signed), .y_signed(y_signed),
    .product(product), .out_valid(out_valid)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(bit sp, logic [17:0] a, logic [17:0] b, bit sa, bit sb);
    longint va, vb, lo, hi;
    if (!sp) begin
      va = sa ? longint'($signed(a)) : longint'(a);
      vb = sb ? longint'($signed(b)) : longint'(b);
      return 36'(va * vb);
    end
    va = sa ? longint'($signed(a[8:0])) : longint'(a[8:0]);
    vb = sb ? longint'($signed(b[8:0])) : longint'(b[8:0]);
    lo = va * vb;
    va = sa ? longint'($signed(a[17:9])) : longint'(a[17:9]);
    vb = sb ? longint'($signed(b[17:9])) : longint'(b[17:9]);
    hi = va * vb;
    return {18'(hi), 18'(lo)};
  endfunction

  task automatic run_op(string req, bit ir, bit orr, bit sp,
                        logic [17:0] a, logic [17:0] b, bit sa, bit sb);
    logic [35:0] e;
    int lat;
    e = model(sp, a, b, sa, sb);
    lat = int'(ir) + int'(orr);
    @(negedge clk);
    in_reg_en = ir; out_reg_en = orr; split_mode = sp;
    x = a; y = b; x_signed = sa; y_signed = sb; in_valid = 1'b1;
    if (lat == 0) begin
      #1;
      chk({req, " product lat0"}, product, e);
      chk({req, " R6 valid lat0"}, 36'(out_valid), 36'd1);
      in_valid = 1'b0;
      #1;
      chk({req, " R6 valid drop lat0"}, 36'(out_valid), 36'd0);
      return;
    end
    @(posedge clk); #1 in_valid = 1'b0;
    if (lat == 2) begin
      chk({req, " R6 no early valid"}, 36'(out_valid), 36'd0);
      @(posedge clk);
    end
    #2;
    chk({req, " product"}, product, e);
    chk({req, " R6 valid"}, 36'(out_valid), 36'd1);
    @(posedge clk); #2;
    chk({req, " R6 valid one cycle"}, 36'(out_valid), 36'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    clr = 1'b1; in_reg_en = 1'b1; out_reg_en = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R8 reset product", product, 36'd0);
    chk("R8 reset valid", 36'(out_valid), 36'd0);
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_full;
    run_op("R1 max unsigned", 1, 1, 0, 18'h3FFFF, 18'h3FFFF, 0, 0);
    run_op("R1 mixed bits",   0, 0, 0, 18'h12345, 18'h0ABCD, 0, 0);
    run_op("R2 neg x neg",    1, 1, 0, 18'h20000, 18'h20000, 1, 1);
    run_op("R2 signed x unsigned y", 0, 0, 0, 18'h3FFFF, 18'h3FFFF, 1, 0);
    run_op("R2 unsigned x signed y", 1, 0, 0, 18'h00123, 18'h3FF00, 0, 1);
  endtask

  task automatic t_split;
    run_op("R3 split unsigned",  0, 0, 1, 18'h3FFFF, 18'h3FFFF, 0, 0);
    run_op("R3 split signed",    1, 1, 1, 18'h201FF, 18'h3FF00, 1, 1);
    run_op("R3 split mixed",     0, 1, 1, 18'h1FE81, 18'h00F07, 1, 0);
    run_op("R9 lane isolate a",  0, 0, 1, 18'h00055, 18'h00033, 0, 0);
    run_op("R9 lane isolate b",  0, 0, 1, 18'h3FE55, 18'h2AA33, 0, 0);
  endtask

  task automatic t_latency;
    run_op("R4 in stage only",  1, 0, 0, 18'h01000, 18'h00777, 0, 0);
    run_op("R5 out stage only", 0, 1, 0, 18'h0F0F0, 18'h00F0F, 1, 1);
    run_op("R5 both stages",    1, 1, 1, 18'h0AAAA, 18'h15555, 0, 1);
  endtask

  task automatic t_hold;
    logic [35:0] e;
    e = model(0, 18'h00321, 18'h00456, 0, 0);
    run_op("R7 prep", 1, 1, 0, 18'h00321, 18'h00456, 0, 0);
    @(negedge clk);
    ce = 1'b0; x = 18'h3ABCD; y = 18'h1F00F; in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R7 hold product", product, e);
    chk("R7 hold valid", 36'(out_valid), 36'd0);
    @(negedge clk); in_valid = 1'b0; ce = 1'b1;
  endtask

  task automatic t_clear;
    @(negedge clk);
    in_reg_en = 1'b1; out_reg_en = 1'b1; split_mode = 1'b0;
    x = 18'h01234; y = 18'h00ABC; x_signed = 1'b0; y_signed = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; clr = 1'b1; ce = 1'b0;
    @(posedge clk); #1 clr = 1'b0;
    #1;
    chk("R8 clear product under ce low", product, 36'd0);
    chk("R8 clear valid under ce low", 36'(out_valid), 36'd0);
    @(negedge clk); ce = 1'b1;
    @(posedge clk); #2;
    chk("R8 cleared stage gives no valid", 36'(out_valid), 36'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    ce = 1'b1; clr = 1'b0; split_mode = 1'b0; in_reg_en = 1'b0; out_reg_en = 1'b0;
    in_valid = 1'b0; x = '0; y = '0; x_signed = 1'b0; y_signed = 1'b0;
    t_reset();
    t_full();
    t_split();
    t_latency();
    t_hold();
    t_clear();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule